// File: doc/BRIEF.md
# On-Die Termination Timing-Class Tracker

This controller-side block follows the DRAM power state and classifies every change of the on-die termination request. Each change falls into one of two classes. In the synchronous class the turn-on and turn-off delays are counted in clocks. In the asynchronous class the power-down delays apply. The class depends on three things: whether clock enable is high, which power-down flavour is in force, and how close the termination edge lies to a power-down entry or exit. The memory controller uses the verdict to choose the right latency when it schedules termination and data.

The flavour is worked out from three inputs: clock enable, an any-bank-open flag and the exit-mode bit. With clock enable low, a bank open and the exit-mode bit at 0, the device is in fast-exit power-down. With clock enable low, a bank open and the exit-mode bit at 1, it is in slow-exit power-down. With clock enable low and all banks idle, it is in precharge power-down. Slow-exit and precharge power-down together form the asynchronous flavour.

The block also holds termination changes off in two situations: during self refresh, and for a settling time after the extended mode register write that enables termination. An edge that arrives while changes are held off is flagged as a violation.

Top module: `odt_class_tracker`

## Requirements
- R1: Reset state. While reset is held and in the first cycle after it, `rpt_vld` and `odt_viol` are 0. `odt_allow` is 0 because the settling window is armed at reset.
- R2: `odt_allow` is 0 whenever `self_ref` is 1.
- R3: `odt_allow` is 0 in the cycle of an `emr_wr` pulse and for SETTLE cycles after it. SETTLE = ceil(MOD_PS/TCK_PS) + MOD_EXTRA, which is 7 by default.
- R4: A change of `odt_req` in a cycle where `odt_allow` is 0 raises `odt_viol` for one cycle, in the next cycle. Such an edge is never reported as a class verdict.
- R5: An allowed edge in a cycle with `cke` = 0, `bank_open` = 1 and `slow_exit` = 0 (fast-exit power-down) gives `rpt_vld` = 1 and `rpt_async` = 0 in the next cycle.
- R6: An allowed edge in a cycle with `cke` = 0 and either `bank_open` = 0 or `slow_exit` = 1 gives `rpt_vld` = 1 and `rpt_async` = 1 in the next cycle.
- R7: Take an allowed edge at cycle t with `cke` = 1 and outside any exit window. If no asynchronous-flavour power-down entry occurs in cycles t+1 to t+ENTRY_MIN-1, the edge is reported synchronous (`rpt_async` = 0) in cycle t+ENTRY_MIN+1.
- R8: If such an edge is followed by an asynchronous-flavour entry in cycle t+k, with 1 ≤ k < ENTRY_MIN, it is reported asynchronous in cycle t+k+1. Entry means the first cycle in which `cke` is seen low.
- R9: An allowed edge in the exit cycle of an asynchronous-flavour power-down, or in the EXIT_MIN-1 cycles after it, is reported asynchronous in the next cycle. The exit cycle is the first cycle with `cke` high again. A later edge follows R7.
- R10: `rpt_on` carries the new request level of the reported edge (1 = turn-on, 0 = turn-off), so both directions are judged under the same rules. An allowed edge that arrives while an earlier edge is still waiting for its R7 verdict replaces it, and the earlier edge is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable level driven to the DRAM |
| bank_open | input | 1 | 1 when any row of any bank is open |
| slow_exit | input | 1 | Exit-mode bit: 1 selects slow-exit power-down |
| self_ref | input | 1 | 1 while the device is in self refresh |
| emr_wr | input | 1 | One-cycle strobe for the write that enables termination |
| odt_req | input | 1 | Termination request level |
| odt_allow | output | 1 | 1 when the termination request may change |
| odt_viol | output | 1 | One-cycle pulse: the request changed while not allowed |
| rpt_vld | output | 1 | One-cycle pulse: a class verdict is presented |
| rpt_async | output | 1 | Verdict class: 1 asynchronous, 0 synchronous |
| rpt_on | output | 1 | Direction of the judged edge: 1 turn-on, 0 turn-off |

## Verification
The hardest case to reach is an active-mode edge followed, inside the short pre-entry window, by a drop of clock enable into the asynchronous flavour. The same case with the fast-exit flavour, where the verdict must stay synchronous, is just as hard. Directed sequences place the edge and the entry at chosen cycle distances. Other sequences place an edge exactly in an exit cycle and then step through the edges of the exit window. A long random phase then mixes short clock-enable pulses, flavour changes, mode writes and self-refresh spans. A behavioural reference model compares every output against the design on every clock.

// File: rtl/odt_class_tracker.sv
module odt_class_tracker #(
  parameter int TCK_PS    = 2500,
  parameter int MOD_PS    = 12000,
  parameter int MOD_EXTRA = 2,
  parameter int ENTRY_MIN = 3,
  parameter int EXIT_MIN  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic bank_open,
  input  logic slow_exit,
  input  logic self_ref,
  input  logic emr_wr,
  input  logic odt_req,
  output logic odt_allow,
  output logic odt_viol,
  output logic rpt_vld,
  output logic rpt_async,
  output logic rpt_on
);
  localparam int SETTLE = (MOD_PS + TCK_PS - 1) / TCK_PS + MOD_EXTRA;
  localparam int SW = $clog2(SETTLE + 1);
  localparam int PW = $clog2(ENTRY_MIN + 1);
  localparam int XW = $clog2(EXIT_MIN + 1);

  logic cke_q, flav_q, odt_q, pend, pend_on;
  logic [PW-1:0] pcnt;
  logic [XW-1:0] xcnt;
  logic [SW-1:0] scnt;

  logic flav, odt_edge, entry_now, exit_now, recent, take;

  assign flav      = ~bank_open | slow_exit;
  assign odt_edge  = odt_req ^ odt_q;
  assign odt_allow = ~self_ref & ~emr_wr & (scnt == '0);
  assign entry_now = cke_q & ~cke & flav;
  assign exit_now  = ~cke_q & cke & flav_q;
  assign recent    = exit_now | (xcnt < XW'(EXIT_MIN));
  assign take      = odt_edge & odt_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      flav_q    <= 1'b0;
      odt_q     <= 1'b0;
      pend      <= 1'b0;
      pend_on   <= 1'b0;
      pcnt      <= '0;
      xcnt      <= XW'(EXIT_MIN);
      scnt      <= SW'(SETTLE);
      odt_viol  <= 1'b0;
      rpt_vld   <= 1'b0;
      rpt_async <= 1'b0;
      rpt_on    <= 1'b0;
    end else begin
      cke_q    <= cke;
      odt_q    <= odt_req;
      odt_viol <= odt_edge & ~odt_allow;
      rpt_vld  <= 1'b0;
      if (!cke) flav_q <= flav;

      if (exit_now)                   xcnt <= XW'(1);
      else if (xcnt < XW'(EXIT_MIN))  xcnt <= xcnt + XW'(1);

      if (emr_wr)           scnt <= SW'(SETTLE);
      else if (scnt != '0)  scnt <= scnt - SW'(1);

      if (take) begin
        if (!cke) begin
          pend      <= 1'b0;
          rpt_vld   <= 1'b1;
          rpt_async <= flav;
          rpt_on    <= odt_req;
        end else if (recent) begin
          pend      <= 1'b0;
          rpt_vld   <= 1'b1;
          rpt_async <= 1'b1;
          rpt_on    <= odt_req;
        end else begin
          pend    <= 1'b1;
          pend_on <= odt_req;
          pcnt    <= PW'(1);
        end
      end else if (pend) begin
        if (pcnt >= PW'(ENTRY_MIN)) begin
          pend      <= 1'b0;
          rpt_vld   <= 1'b1;
          rpt_async <= 1'b0;
          rpt_on    <= pend_on;
        end else if (entry_now) begin
          pend      <= 1'b0;
          rpt_vld   <= 1'b1;
          rpt_async <= 1'b1;
          rpt_on    <= pend_on;
        end else begin
          pcnt <= pcnt + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/odt_class_tracker_chk.sv
module odt_class_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic bank_open,
  input logic slow_exit,
  input logic self_ref,
  input logic emr_wr,
  input logic odt_req,
  input logic odt_allow,
  input logic odt_viol,
  input logic rpt_vld,
  input logic rpt_async,
  input logic rpt_on
);
  logic [1:0] age;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  AST_SR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref |-> !odt_allow); // R2

  AST_EMR_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    emr_wr |=> !odt_allow); // R3

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    odt_viol |-> !$past(odt_allow)); // R4

  AST_FAST_PD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cke) && $past(bank_open) && !$past(slow_exit) && $past(odt_allow)
     && ($past(odt_req) != $past(odt_req, 2))) |-> (rpt_vld && !rpt_async)); // R5

  AST_ASYNC_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cke) && (!$past(bank_open) || $past(slow_exit)) && $past(odt_allow)
     && ($past(odt_req) != $past(odt_req, 2))) |-> (rpt_vld && rpt_async)); // R6

  AST_EXIT_EDGE_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cke) && !$past(cke, 2) && (!$past(bank_open, 2) || $past(slow_exit, 2))
     && $past(odt_allow) && ($past(odt_req) != $past(odt_req, 2))) |-> (rpt_vld && rpt_async)); // R9
endmodule

bind odt_class_tracker odt_class_tracker_chk u_chk (.*);

// File: tb/odt_class_tracker_bench.sv
`timescale 1ns/1ps
module odt_class_tracker_bench;
  localparam int ENTRY_MIN = 3;
  localparam int EXIT_MIN  = 8;
  localparam int SETTLE    = 7;

  logic clk = 0, rst_n = 0;
  logic cke = 1, bank_open = 0, slow_exit = 0, self_ref = 0, emr_wr = 0, odt_req = 0;
  logic odt_allow, odt_viol, rpt_vld, rpt_async, rpt_on;

  odt_class_tracker u_odt_class_tracker (.*);

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit run = 0, done = 0;
  string cur_req = "R1";

  int n, xt, pt, ms;
  bit mcke, mflav, modt, pend, pon;
  bit e_vld, e_async, e_on, e_viol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0; xt = -1000; pt = 0; ms = SETTLE;
      mcke = 1; mflav = 0; modt = 0; pend = 0; pon = 0;
      e_vld = 0; e_async = 0; e_on = 0; e_viol = 0;
    end else begin
      bit edg, ok, fl, entry, ext, rec;
      n++;
      fl    = !bank_open || slow_exit;
      edg   = odt_req != modt;
      ok    = !self_ref && !emr_wr && ms == 0;
      entry = mcke && !cke && fl;
      ext   = !mcke && cke && mflav;
      rec   = ext || (n - xt) < EXIT_MIN;
      e_viol = edg && !ok;
      e_vld  = 0;
      if (edg && ok) begin
        if (!cke)     begin pend = 0; e_vld = 1; e_async = fl; e_on = odt_req; end
        else if (rec) begin pend = 0; e_vld = 1; e_async = 1;  e_on = odt_req; end
        else          begin pend = 1; pt = n; pon = odt_req; end
      end else if (pend) begin
        if (n - pt >= ENTRY_MIN) begin pend = 0; e_vld = 1; e_async = 0; e_on = pon; end
        else if (entry)          begin pend = 0; e_vld = 1; e_async = 1; e_on = pon; end
      end
      if (ext) xt = n;
      if (!cke) mflav = fl;
      mcke = cke;
      modt = odt_req;
      if (emr_wr) ms = SETTLE; else if (ms > 0) ms--;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at t=%0t", what, cur_req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run && !done) begin
      chk("allow R2 R3", odt_allow, !self_ref && !emr_wr && ms == 0);
      chk("viol R4", odt_viol, e_viol);
      chk("rpt_vld", rpt_vld, e_vld);
      if (e_vld) begin
        chk("rpt_async", rpt_async, e_async);
        chk("rpt_on R10", rpt_on, e_on);
      end
    end
  end

  task automatic drive(bit c, bit b, bit s, bit sr, bit e, bit o);
    @(negedge clk); #1;
    cke = c; bank_open = b; slow_exit = s; self_ref = sr; emr_wr = e; odt_req = o;
  endtask

  task automatic hold(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); #1; emr_wr = 0;
    end
  endtask

  task automatic toggle();
    @(negedge clk); #1; odt_req = ~odt_req; emr_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset rpt_vld R1", rpt_vld, 0);
    chk("reset viol R1", odt_viol, 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("post-reset allow R1", odt_allow, 0);
    chk("post-reset rpt_vld R1", rpt_vld, 0);
    run = 1;
    cur_req = "R3"; hold(SETTLE + 2);

    cur_req = "R7"; drive(1, 1, 0, 0, 0, 1); hold(8);
    cur_req = "R10"; drive(1, 1, 0, 0, 0, 0); hold(8);
    drive(1, 1, 0, 0, 0, 1); toggle(); hold(8);

    cur_req = "R8"; toggle(); drive(0, 0, 0, 0, 0, odt_req); hold(6);
    cur_req = "R9"; drive(1, 0, 0, 0, 0, ~odt_req); hold(3); toggle(); hold(EXIT_MIN + 2);
    toggle(); hold(6);

    cur_req = "R8"; drive(1, 1, 1, 0, 0, ~odt_req); drive(0, 1, 1, 0, 0, odt_req); hold(4);
    cur_req = "R6"; toggle(); hold(3);
    cur_req = "R9"; drive(1, 1, 1, 0, 0, odt_req); hold(EXIT_MIN - 2); toggle(); hold(2); toggle(); hold(6);

    cur_req = "R7"; drive(1, 1, 0, 0, 0, ~odt_req); hold(1); drive(0, 1, 0, 0, 0, odt_req); hold(5);
    cur_req = "R5"; toggle(); hold(3); toggle(); hold(3);
    drive(1, 1, 0, 0, 0, odt_req); hold(1); toggle(); hold(6);

    cur_req = "R4"; drive(1, 1, 0, 0, 1, odt_req); hold(2); toggle(); hold(SETTLE + 2);
    cur_req = "R2"; drive(0, 0, 0, 1, 0, odt_req); hold(2); toggle(); hold(3);
    drive(1, 0, 0, 0, 0, odt_req); hold(EXIT_MIN + 4);

    cur_req = "R7 R8 R9";
    for (int i = 0; i < 3000; i++) begin
      bit c, b, s, sr, e, o;
      c  = ($urandom % 6) != 0 || (!cke && ($urandom % 3) == 0);
      if (!cke && ($urandom % 4) != 0) c = 0;
      b  = ($urandom % 2);
      s  = ($urandom % 2);
      sr = ($urandom % 60) == 0;
      e  = ($urandom % 90) == 0;
      o  = (($urandom % 4) == 0) ? ~odt_req : odt_req;
      drive(c, b, s, sr, e, o);
    end
    hold(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule